// File: doc/BRIEF.md
# Oversampled Camera Capture with Block-Averaging Downscaler

This block takes the 8-bit parallel output of an image sensor (pixel strobe, line-valid and frame-sync included) and turns it into a reduced frame in memory. Every camera input is treated as plain data. It is resynchronised into the system clock, which runs at roughly ten times the pixel-strobe rate, and the strobe's rising edge is found by comparing consecutive samples. Two consecutive captured bytes make one 16-bit RGB565 pixel.

Each 4x4 group of input pixels is summed per colour channel in a per-column accumulator and divided by sixteen. The result is packed into one byte as RGB332 and written to a frame memory through a single-cycle write port. With the default 640x480 input, the output frame is 160x120. The block also divides the system clock down to make the sensor's master clock.

Top module: `cam_capture_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `mem_we` is 0 and `cam_mclk` is 0.
- R2: `cam_mclk` toggles every `MCLK_HALF` system cycles. It first toggles `MCLK_HALF` cycles after reset is released.
- R3: A byte is taken only on a sampled rising edge of `cam_pclk`, and only if the synchronised `cam_vsync` is low and `cam_href` is high at that edge. Holding the strobe high captures nothing more. Strobe edges while line-valid is low or frame-sync is high have no effect on later writes.
- R4: Bytes pair up in arrival order. The first byte is bits 15:8 of the RGB565 word and the second byte is bits 7:0. Red is bits 15:11, green is bits 10:5 and blue is bits 4:0.
- R5: An unpaired first byte is discarded when line-valid falls or frame-sync is high. The next byte starts a new pair.
- R6: Each output channel is the sum of that channel over the 16 input pixels of a 4x4 block, shifted right by 4, with no rounding.
- R7: The output byte is RGB332: bits 7:5 are the top 3 bits of averaged red, bits 4:2 are the top 3 bits of averaged green, and bits 1:0 are the top 2 bits of averaged blue.
- R8: Exactly one write is made per completed block, after its bottom-right pixel arrives. The address is block_row*(IMG_W/4)+block_col, and writes follow raster order of completion.
- R9: A rising frame-sync restarts pixel position at row 0, column 0. A block left partially summed by an aborted frame produces no write and does not affect the next frame.
- R10: A line-valid pulse that delivers no complete pixel does not advance the row count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, about ten times the pixel-strobe rate |
| rst | input | 1 | Synchronous active-high reset |
| cam_pclk | input | 1 | Camera pixel strobe, sampled as data |
| cam_href | input | 1 | Camera line-valid, active high |
| cam_vsync | input | 1 | Camera frame-sync, active high |
| cam_data | input | 8 | Camera byte bus |
| cam_mclk | output | 1 | Master clock driven to the camera |
| mem_we | output | 1 | Frame memory write enable, one cycle per block |
| mem_addr | output | ADDR_W | Frame memory write address |
| mem_wdata | output | 8 | RGB332 reduced pixel |

## Verification
The delicate overlap is a frame-sync rise and a pixel-strobe rise landing in the same sampled cycle while a first byte is still waiting for its partner. The strobe edge must not complete a pixel, and the new frame must pair from its own first byte. The bench provokes this by raising both pins on the same edge just after a lone byte, then streams a full frame. Every write of the next frame is compared in order against the queued expected address and RGB332 value, so a stale half-pixel or a shifted pairing shows up as a mismatch.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int BLK_LOG2 = 2;

    typedef struct packed {
        logic [4:0] r;
        logic [5:0] g;
        logic [4:0] b;
    } px565_t;

    typedef struct packed {
        logic [8:0] r;
        logic [9:0] g;
        logic [8:0] b;
    } blksum_t;

    typedef enum logic {PH_HI, PH_LO} phase_t;

    function automatic px565_t join565(input logic [7:0] hi, input logic [7:0] lo);
        return px565_t'({hi, lo});
    endfunction

    function automatic blksum_t widen(input px565_t p);
        blksum_t s;
        s.r = {4'b0, p.r};
        s.g = {4'b0, p.g};
        s.b = {4'b0, p.b};
        return s;
    endfunction

    function automatic blksum_t add_sum(input blksum_t a, input blksum_t b);
        blksum_t s;
        s.r = a.r + b.r;
        s.g = a.g + b.g;
        s.b = a.b + b.b;
        return s;
    endfunction

    // sum>>4 gives the average; its top bits are the top bits of the sum
    function automatic logic [7:0] pack332(input blksum_t s);
        return {s.r[8:6], s.g[9:7], s.b[8:7]};
    endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cap_edges.sv
module cap_edges (
    input  logic clk,
    input  logic rst,
    input  logic pclk_s,
    input  logic href_s,
    input  logic vsync_s,
    output logic pclk_rise,
    output logic href_fall,
    output logic vsync_rise
);
    logic pclk_p, href_p, vsync_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            pclk_p  <= 1'b0;
            href_p  <= 1'b0;
            vsync_p <= 1'b0;
        end else begin
            pclk_p  <= pclk_s;
            href_p  <= href_s;
            vsync_p <= vsync_s;
        end
    end

    assign pclk_rise  = pclk_s & ~pclk_p;
    assign href_fall  = href_p & ~href_s;
    assign vsync_rise = vsync_s & ~vsync_p;
endmodule

// File: rtl/cap_pair.sv
module cap_pair
    import cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pclk_rise,
    input  logic       href_s,
    input  logic       vsync_s,
    input  logic [7:0] data_s,
    output logic       pix_valid,
    output px565_t     pix
);
    phase_t     phase;
    logic [7:0] hi_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_HI;
            hi_byte   <= '0;
            pix_valid <= 1'b0;
            pix       <= '0;
        end else begin
            pix_valid <= 1'b0;
            if (vsync_s || !href_s) begin
                phase <= PH_HI;
            end else if (pclk_rise) begin
                if (phase == PH_HI) begin
                    hi_byte <= data_s;
                    phase   <= PH_LO;
                end else begin
                    pix       <= join565(hi_byte, data_s);
                    pix_valid <= 1'b1;
                    phase     <= PH_HI;
                end
            end
        end
    end
endmodule

// File: rtl/cap_scale.sv
module cap_scale
    import cap_pkg::*;
#(
    parameter int IMG_W  = 640,
    parameter int IMG_H  = 480,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              line_end,
    input  logic              pix_valid,
    input  px565_t            pix,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        wdata
);
    localparam int OUT_W = IMG_W >> BLK_LOG2;
    localparam int XW    = $clog2(IMG_W);
    localparam int YW    = $clog2(IMG_H);
    localparam int CW    = XW - BLK_LOG2;
    localparam int BW    = YW - BLK_LOG2;

    blksum_t acc [OUT_W];

    logic [XW:0] x;
    logic [YW:0] y;

    logic          in_range, first_px, last_px;
    logic [CW-1:0] col;
    logic [BW-1:0] band;
    blksum_t       sum_next;

    always_comb begin
        in_range = (x < (XW+1)'(IMG_W)) && (y < (YW+1)'(IMG_H));
        col      = x[XW-1:BLK_LOG2];
        band     = y[YW-1:BLK_LOG2];
        first_px = (x[BLK_LOG2-1:0] == '0) && (y[BLK_LOG2-1:0] == '0);
        last_px  = (x[BLK_LOG2-1:0] == '1) && (y[BLK_LOG2-1:0] == '1);
        sum_next = first_px ? widen(pix) : add_sum(acc[col], widen(pix));
    end

    always_ff @(posedge clk) begin
        if (pix_valid && in_range && !last_px) begin
            acc[col] <= sum_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            x     <= '0;
            y     <= '0;
            we    <= 1'b0;
            addr  <= '0;
            wdata <= '0;
        end else begin
            we <= 1'b0;
            if (pix_valid && in_range) begin
                x <= x + 1'b1;
                if (last_px) begin
                    we    <= 1'b1;
                    addr  <= ADDR_W'(band) * ADDR_W'(OUT_W) + ADDR_W'(col);
                    wdata <= pack332(sum_next);
                end
            end
            if (line_end) begin
                x <= '0;
                if ((x != '0 || pix_valid) && y != (YW+1)'(IMG_H)) begin
                    y <= y + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cam_capture_top.sv
module cam_capture_top
    import cap_pkg::*;
#(
    parameter int IMG_W     = 640,
    parameter int IMG_H     = 480,
    parameter int MCLK_HALF = 5,
    parameter int ADDR_W    = $clog2((IMG_W >> BLK_LOG2) * (IMG_H >> BLK_LOG2))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cam_pclk,
    input  logic              cam_href,
    input  logic              cam_vsync,
    input  logic [7:0]        cam_data,
    output logic              cam_mclk,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    localparam int MW = (MCLK_HALF > 1) ? $clog2(MCLK_HALF) : 1;

    logic [MW-1:0] mclk_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mclk_cnt <= '0;
            cam_mclk <= 1'b0;
        end else if (mclk_cnt == MW'(MCLK_HALF - 1)) begin
            mclk_cnt <= '0;
            cam_mclk <= ~cam_mclk;
        end else begin
            mclk_cnt <= mclk_cnt + 1'b1;
        end
    end

    logic [2:0] ctl_s;
    logic [7:0] data_s;
    logic       pclk_s, href_s, vsync_s;
    logic       pclk_rise, href_fall, vsync_rise;
    logic       pix_valid;
    px565_t     pix;

    cap_sync #(.W(3)) i_sync_ctl (
        .clk(clk), .rst(rst), .d({cam_pclk, cam_href, cam_vsync}), .q(ctl_s)
    );
    cap_sync #(.W(8)) i_sync_dat (
        .clk(clk), .rst(rst), .d(cam_data), .q(data_s)
    );
    assign {pclk_s, href_s, vsync_s} = ctl_s;

    cap_edges i_edges (
        .clk(clk), .rst(rst), .pclk_s(pclk_s), .href_s(href_s), .vsync_s(vsync_s),
        .pclk_rise(pclk_rise), .href_fall(href_fall), .vsync_rise(vsync_rise)
    );

    cap_pair i_pair (
        .clk(clk), .rst(rst), .pclk_rise(pclk_rise), .href_s(href_s),
        .vsync_s(vsync_s), .data_s(data_s), .pix_valid(pix_valid), .pix(pix)
    );

    cap_scale #(.IMG_W(IMG_W), .IMG_H(IMG_H), .ADDR_W(ADDR_W)) i_scale (
        .clk(clk), .rst(rst), .frame_start(vsync_rise), .line_end(href_fall),
        .pix_valid(pix_valid), .pix(pix), .we(mem_we), .addr(mem_addr),
        .wdata(mem_wdata)
    );
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
    parameter int MCLK_HALF = 5,
    parameter int ADDR_W    = 15,
    parameter int N_OUT     = 19200
) (
    input logic              clk,
    input logic              rst,
    input logic              cam_mclk,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              pix_valid,
    input logic              pclk_rise,
    input logic              href_s,
    input logic              vsync_s
);
    logic        mclk_q;
    int unsigned run;

    always_ff @(posedge clk) begin
        if (rst) begin
            mclk_q <= 1'b0;
            run    <= 0;
        end else begin
            mclk_q <= cam_mclk;
            run    <= (cam_mclk != mclk_q) ? 1 : run + 1;
        end
    end

    AST_MCLK_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (cam_mclk != mclk_q) |-> (run == MCLK_HALF)); // R2

    AST_CAPTURE_GATED: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> $past(pclk_rise && href_s && !vsync_s)); // R3

    AST_PAIR_SPACING: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> !pix_valid); // R4

    AST_WRITE_AFTER_PIXEL: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(pix_valid)); // R8

    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (int'(mem_addr) < N_OUT)); // R8
endmodule

bind cam_capture_top cap_checker #(
    .MCLK_HALF(MCLK_HALF),
    .ADDR_W(ADDR_W),
    .N_OUT((IMG_W / 4) * (IMG_H / 4))
) i_cap_checker (
    .clk(clk), .rst(rst), .cam_mclk(cam_mclk), .mem_we(mem_we),
    .mem_addr(mem_addr), .pix_valid(pix_valid), .pclk_rise(pclk_rise),
    .href_s(href_s), .vsync_s(vsync_s)
);

// File: tb/test_cam_capture_top.sv
module test_cam_capture_top;
    localparam int W      = 16;
    localparam int H      = 8;
    localparam int HALF   = 5;
    localparam int OW     = W / 4;
    localparam int AW     = $clog2((W / 4) * (H / 4));

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cam_pclk = 1'b0, cam_href = 1'b0, cam_vsync = 1'b0;
    logic [7:0]    cam_data = '0;
    logic          cam_mclk, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;

    int tests = 0, fails = 0;
    int exp_a[$];
    int exp_d[$];
    bit done = 0;

    always #4 clk = ~clk;

    cam_capture_top #(.IMG_W(W), .IMG_H(H), .MCLK_HALF(HALF)) i_cam_capture_top (
        .clk(clk), .rst(rst), .cam_pclk(cam_pclk), .cam_href(cam_href),
        .cam_vsync(cam_vsync), .cam_data(cam_data), .cam_mclk(cam_mclk),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // behavioural model of the master clock (R2)
    int  mcnt = 0;
    bit  exp_mclk = 0;
    always @(posedge clk) begin
        if (rst) begin mcnt = 0; exp_mclk = 0; end
        else if (mcnt == HALF - 1) begin mcnt = 0; exp_mclk = ~exp_mclk; end
        else mcnt = mcnt + 1;
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            tests++;
            if (cam_mclk !== exp_mclk) begin
                fails++;
                $display("FAIL R2 mclk actual=%0b expected=%0b", cam_mclk, exp_mclk);
            end
            if (mem_we === 1'b1) begin
                tests++;
                if (exp_a.size() == 0) begin
                    fails++;
                    $display("FAIL R8 unexpected write actual addr=%0d data=%02h expected none",
                             mem_addr, mem_wdata);
                end else begin
                    int a, d;
                    a = exp_a.pop_front();
                    d = exp_d.pop_front();
                    if (int'(mem_addr) != a || int'(mem_wdata) != d) begin
                        fails++;
                        $display("FAIL R6 R7 R8 write actual addr=%0d data=%02h expected addr=%0d data=%02h",
                                 mem_addr, mem_wdata, a, d);
                    end
                end
            end
        end
    end

    function automatic logic [15:0] pixel(int mode, int x, int y);
        case (mode)
            0: return {8'(x * 16 + y), 8'(x * 3 + y * 29)};
            1: return 16'hFFFF;
            default: return {8'(x * 37 + y * 91 + 17), 8'(x * 113 + y * 59 + 5)};
        endcase
    endfunction

    // expected writes for the blocks whose four rows are all delivered (R6 R7 R8)
    task automatic expect_frame(int mode, int rows);
        for (int by = 0; by < rows / 4; by++)
            for (int bx = 0; bx < OW; bx++) begin
                int sr = 0, sg = 0, sb = 0;
                for (int dy = 0; dy < 4; dy++)
                    for (int dx = 0; dx < 4; dx++) begin
                        logic [15:0] p;
                        p = pixel(mode, bx * 4 + dx, by * 4 + dy);
                        sr += p[15:11]; sg += p[10:5]; sb += p[4:0];
                    end
                exp_a.push_back(by * OW + bx);
                exp_d.push_back((((sr / 16) >> 2) << 5) | (((sg / 16) >> 3) << 2) | ((sb / 16) >> 3));
            end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(logic [7:0] b, int lo_len, int hi_len);
        cam_data = b; cam_pclk = 1'b0;
        cyc(lo_len);
        cam_pclk = 1'b1;
        cyc(hi_len);
        cam_pclk = 1'b0;
    endtask

    task automatic send_frame(int mode, int rows, bit noise, int lo_len, int hi_len);
        cam_vsync = 1'b1;
        if (noise) begin send_byte(8'hA5, 3, 3); send_byte(8'h5A, 3, 3); end  // R3 during frame-sync
        cyc(10);
        cam_vsync = 1'b0;
        cyc(10);
        for (int y = 0; y < rows; y++) begin
            cam_href = 1'b1;
            cyc(3);
            for (int x = 0; x < W; x++) begin
                logic [15:0] p;
                p = pixel(mode, x, y);
                send_byte(p[15:8], lo_len, hi_len);
                send_byte(p[7:0], lo_len, hi_len);
            end
            cyc(3);
            cam_href = 1'b0;
            cyc(8);
            if (noise) begin
                send_byte(8'h33, 3, 3);        // R3 strobe with line-valid low
                send_byte(8'hCC, 3, 3);
                cam_href = 1'b1; cyc(3);
                send_byte(8'h77, 4, 4);        // R5 lone byte, R10 no row advance
                cyc(3); cam_href = 1'b0; cyc(8);
            end
        end
        cyc(20);
    endtask

    task automatic drain(string tag);
        cyc(20);
        tests++;
        if (exp_a.size() != 0) begin
            fails++;
            $display("FAIL %s missing writes actual=%0d pending expected=0", tag, exp_a.size());
            exp_a.delete(); exp_d.delete();
        end
    endtask

    initial begin
        cyc(3);
        tests++;   // R1 during reset
        if (mem_we !== 1'b0 || cam_mclk !== 1'b0) begin
            fails++;
            $display("FAIL R1 in reset actual we=%0b mclk=%0b expected 0 0", mem_we, cam_mclk);
        end
        rst = 1'b0;
        @(posedge clk); #1;
        tests++;   // R1 first cycle after release
        if (mem_we !== 1'b0 || cam_mclk !== 1'b0) begin
            fails++;
            $display("FAIL R1 after reset actual we=%0b mclk=%0b expected 0 0", mem_we, cam_mclk);
        end

        // R4 R6 R7 R8: gradient frame, regular strobe
        expect_frame(0, H); send_frame(0, H, 0, 5, 5); drain("R8 frame0");
        // R6: saturated channels, truncation without overflow
        expect_frame(1, H); send_frame(1, H, 0, 5, 5); drain("R6 frame1");
        // R3 R5 R10: stray strobes and lone bytes, long strobe-high time
        expect_frame(2, H); send_frame(2, H, 1, 3, 8); drain("R3 R5 R10 frame2");
        // R9: aborted frame after two rows, then a full frame
        send_frame(2, 2, 0, 5, 5); drain("R9 abort");
        expect_frame(0, H); send_frame(0, H, 0, 4, 6); drain("R9 after abort");
        // R5 R9: lone byte, then frame-sync and strobe rise on the same edge
        cam_href = 1'b1; cyc(3);
        send_byte(8'h9C, 5, 5);
        cam_data = 8'h3E; cyc(4);
        cam_vsync = 1'b1; cam_pclk = 1'b1;
        cyc(5); cam_pclk = 1'b0; cam_href = 1'b0;
        cyc(5);
        drain("R5 coincident");
        expect_frame(2, H); send_frame(2, H, 0, 5, 5); drain("R5 R9 coincident next frame");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule